// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a physical page number (4 KiB pages) into the DRAM chip-select row that holds it. Software programs eight cumulative boundary bytes, a row attribute word and a controller mode word through a small write port. Because the boundaries are cumulative, each row covers the pages between the previous row's boundary and its own. A row whose boundary equals its predecessor's holds no memory and never matches.

A lookup port takes a page number. One cycle later it returns the matching row, that row's first and last page, its per-channel page count, its device width and the ECC scheme that applies to it. If no row matches, it raises a miss flag. A population vector shows at all times which rows hold memory. Boundary granularity, channel count and ECC enable all come from fields in the mode word.

Top module: `row_boundary_decoder`

## Requirements
- R1: A write with `cfgAddr` 0..7 sets the boundary byte of the row with that index (data bits 7:0). Address 8 sets the attribute word and address 9 sets the mode word. Addresses 10..15 are ignored. A write is visible to a lookup issued in the next cycle or later. A lookup issued in the same cycle as a write still uses the old configuration.
- R2: After reset all boundaries, the attribute word and the mode word are zero. `rowPop` is 0, `rsValid` is 0, and every lookup misses.
- R3: `rsValid` is high in exactly the cycle after the cycle in which `lkValid` was high.
- R4: Row r's page count boundary is its boundary byte shifted left by 13 when mode bit 18 is 0, or by 14 when it is 1. Mode bit 19 has no effect. A matched row reports first page = the previous row's page boundary (0 for row 0) and last page = its own boundary minus 1.
- R5: `rowPop[r]` is 1 exactly when row r's boundary byte differs from row r-1's byte (row 0 compares against 0).
- R6: A lookup matches the lowest-indexed populated row whose page boundary is greater than the requested page. It reports that row's index on `rsRow`.
- R7: When no row matches, `rsMiss` is 1 and `rsRow`, `rsFirst`, `rsLast`, `rsChanPages`, `rsX4` and `rsEcc` are all 0.
- R8: `rsX4` equals bit 4*row+3 of the attribute word (1 = x4 devices, 0 = x8).
- R9: `rsEcc` is 0 when mode bits 21:20 are both zero. Otherwise it is 2 (4-bit symbol correction) when mode bit 22 (dual channel) is set and the row is x4, and 1 (SECDED) in every other case.
- R10: `rsChanPages` is the row's size (boundary minus previous boundary) halved when mode bit 22 is set, and the full size when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register index |
| cfgWrData | input | 32 | Configuration write data |
| lkValid | input | 1 | Lookup request |
| lkPage | input | 22 | Page number to look up |
| rsValid | output | 1 | Lookup result valid |
| rsMiss | output | 1 | No populated row holds the page |
| rsRow | output | 3 | Matching row index |
| rsFirst | output | 22 | First page of the matching row |
| rsLast | output | 22 | Last page of the matching row |
| rsChanPages | output | 22 | Pages of the row per channel |
| rsX4 | output | 1 | Matching row uses x4 devices |
| rsEcc | output | 2 | ECC scheme: 0 none, 1 SECDED, 2 4-bit symbol |
| rowPop | output | 8 | Per-row population flags |

## Verification
Every lookup result is due in the cycle after its request, and `rowPop` reflects a write from the cycle after that write. The bench model takes the request and the write at the same rising edge, in that order, so a write that arrives alongside a lookup does not affect it. The model's expectations are compared against the outputs at the following falling edge, one cycle after the request. A few directed lookups also read the result at that same falling edge and compare it with hand-worked values: boundary edges, empty rows, pages past the end, and a write issued together with a lookup.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

  typedef enum logic [1:0] {
    ECC_NONE   = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_SYM4   = 2'd2
  } eccMode_e;

  // Strobes from the control decode into the datapath.
  typedef struct packed {
    logic wrBound;
    logic wrAttr;
    logic wrMode;
    logic lookup;
  } rowdecStb_t;

endpackage

// File: rtl/rowdec_ctrl.sv
module rowdec_ctrl
  import rowdec_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int ROW_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              lkValid,
  output rowdecStb_t        stb,
  output logic [ROW_W-1:0]  rowSel
);

  always_comb begin
    stb         = '0;
    stb.wrBound = cfgWrEn && (cfgAddr < ADDR_W'(ROWS));
    stb.wrAttr  = cfgWrEn && (cfgAddr == ADDR_W'(ROWS));
    stb.wrMode  = cfgWrEn && (cfgAddr == ADDR_W'(ROWS + 1));
    stb.lookup  = lkValid;
    rowSel      = cfgAddr[ROW_W-1:0];
  end

  // R1
  wr_single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrBound, stb.wrAttr, stb.wrMode}));

endmodule

// File: rtl/rowdec_dp.sv
module rowdec_dp
  import rowdec_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int ROW_W      = 3,
  parameter int BOUND_W    = 8,
  parameter int DATA_W     = 32,
  parameter int BASE_SHIFT = 13,
  parameter int PAGE_W     = 22,
  parameter int GRAN_BIT   = 18,
  parameter int ECC_LO     = 20,
  parameter int DUAL_BIT   = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  rowdecStb_t        stb,
  input  logic [ROW_W-1:0]  rowSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [PAGE_W-1:0] lkPage,
  output logic              rsValid,
  output logic              rsMiss,
  output logic [ROW_W-1:0]  rsRow,
  output logic [PAGE_W-1:0] rsFirst,
  output logic [PAGE_W-1:0] rsLast,
  output logic [PAGE_W-1:0] rsChanPages,
  output logic              rsX4,
  output logic [1:0]        rsEcc,
  output logic [ROWS-1:0]   rowPop
);

  logic [BOUND_W-1:0] bound [ROWS];
  logic [ROWS-1:0]    x4Bits;
  logic               modeGran;
  logic               modeEccOn;
  logic               modeDual;
  logic               unusedBits;

  assign unusedBits = ^cfgWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) bound[r] <= '0;
      x4Bits    <= '0;
      modeGran  <= 1'b0;
      modeEccOn <= 1'b0;
      modeDual  <= 1'b0;
    end else begin
      if (stb.wrBound) bound[rowSel] <= cfgWrData[BOUND_W-1:0];
      if (stb.wrAttr)
        for (int r = 0; r < ROWS; r++) x4Bits[r] <= cfgWrData[4*r+3];
      if (stb.wrMode) begin
        modeGran  <= cfgWrData[GRAN_BIT];
        modeEccOn <= |cfgWrData[ECC_LO+1:ECC_LO];
        modeDual  <= cfgWrData[DUAL_BIT];
      end
    end
  end

  // Per-row page boundaries and match flags.
  logic [PAGE_W-1:0] cum     [ROWS];
  logic [PAGE_W-1:0] prevCum [ROWS];
  logic [ROWS-1:0]   hitVec;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [PAGE_W-1:0] wide;
    assign wide   = PAGE_W'(bound[r]);
    assign cum[r] = modeGran ? (wide << (BASE_SHIFT + 1)) : (wide << BASE_SHIFT);
    if (r == 0) begin : g_first
      assign prevCum[r] = '0;
      assign rowPop[r]  = (bound[r] != '0);
    end else begin : g_rest
      assign prevCum[r] = cum[r-1];
      assign rowPop[r]  = (bound[r] != bound[r-1]);
    end
    assign hitVec[r] = rowPop[r] && (lkPage < cum[r]);
  end

  logic              hitAny;
  logic [ROW_W-1:0]  hitIdx;
  logic [PAGE_W-1:0] selSize;
  logic              selX4;
  logic [1:0]        selEcc;

  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (hitVec[r]) begin
        hitAny = 1'b1;
        hitIdx = ROW_W'(r);
      end
    end
    selSize = cum[hitIdx] - prevCum[hitIdx];
    selX4   = x4Bits[hitIdx];
    if (!modeEccOn)              selEcc = ECC_NONE;
    else if (modeDual && selX4)  selEcc = ECC_SYM4;
    else                         selEcc = ECC_SECDED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsValid     <= 1'b0;
      rsMiss      <= 1'b0;
      rsRow       <= '0;
      rsFirst     <= '0;
      rsLast      <= '0;
      rsChanPages <= '0;
      rsX4        <= 1'b0;
      rsEcc       <= ECC_NONE;
    end else begin
      rsValid     <= stb.lookup;
      rsMiss      <= !hitAny;
      rsRow       <= hitAny ? hitIdx : '0;
      rsFirst     <= hitAny ? prevCum[hitIdx] : '0;
      rsLast      <= hitAny ? (cum[hitIdx] - PAGE_W'(1)) : '0;
      rsChanPages <= !hitAny ? '0 : (modeDual ? (selSize >> 1) : selSize);
      rsX4        <= hitAny && selX4;
      rsEcc       <= hitAny ? selEcc : ECC_NONE;
    end
  end

  // R3
  lk_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lookup |=> rsValid);

  // R6
  hit_covers_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && !rsMiss) |-> ($past(lkPage) <= rsLast));

  // R7
  miss_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsMiss |-> (rsRow == '0 && rsChanPages == '0 && !rsX4 && rsEcc == ECC_NONE));

  // R9
  sym4_needs_dual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && rsEcc == ECC_SYM4) |-> (rsX4 && $past(modeDual)));

  // R5
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.wrBound) |-> $stable(rowPop));

endmodule

// File: rtl/row_boundary_decoder.sv
module row_boundary_decoder
  import rowdec_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int BOUND_W    = 8,
  parameter int DATA_W     = 32,
  parameter int BASE_SHIFT = 13,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int ADDR_W    = ROW_W + 1,
  localparam int PAGE_W    = BOUND_W + BASE_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              lkValid,
  input  logic [PAGE_W-1:0] lkPage,
  output logic              rsValid,
  output logic              rsMiss,
  output logic [ROW_W-1:0]  rsRow,
  output logic [PAGE_W-1:0] rsFirst,
  output logic [PAGE_W-1:0] rsLast,
  output logic [PAGE_W-1:0] rsChanPages,
  output logic              rsX4,
  output logic [1:0]        rsEcc,
  output logic [ROWS-1:0]   rowPop
);

  rowdecStb_t       stb;
  logic [ROW_W-1:0] rowSel;

  rowdec_ctrl #(.ROWS(ROWS), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .lkValid(lkValid), .stb(stb), .rowSel(rowSel)
  );

  rowdec_dp #(
    .ROWS(ROWS), .ROW_W(ROW_W), .BOUND_W(BOUND_W), .DATA_W(DATA_W),
    .BASE_SHIFT(BASE_SHIFT), .PAGE_W(PAGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rowSel(rowSel), .cfgWrData(cfgWrData),
    .lkPage(lkPage), .rsValid(rsValid), .rsMiss(rsMiss), .rsRow(rsRow),
    .rsFirst(rsFirst), .rsLast(rsLast), .rsChanPages(rsChanPages),
    .rsX4(rsX4), .rsEcc(rsEcc), .rowPop(rowPop)
  );

endmodule

// File: tb/row_boundary_decoder_test.sv
module row_boundary_decoder_test;

  localparam int PW   = 22;
  localparam int MASK = (1 << PW) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        lkValid = 1'b0;
  logic [21:0] lkPage = '0;
  logic        rsValid, rsMiss, rsX4;
  logic [2:0]  rsRow;
  logic [21:0] rsFirst, rsLast, rsChanPages;
  logic [1:0]  rsEcc;
  logic [7:0]  rowPop;

  int checks = 0;
  int failures = 0;

  row_boundary_decoder uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .lkValid(lkValid), .lkPage(lkPage),
    .rsValid(rsValid), .rsMiss(rsMiss), .rsRow(rsRow), .rsFirst(rsFirst),
    .rsLast(rsLast), .rsChanPages(rsChanPages), .rsX4(rsX4), .rsEcc(rsEcc),
    .rowPop(rowPop)
  );

  always #4 clk = ~clk;

  // Behavioural reference state.
  int mBound[8];
  int mAttr = 0;
  int mMode = 0;
  int eValid = 0, eMiss = 0, eRow = 0, eFirst = 0, eLast = 0, eChan = 0, eX4 = 0, eEcc = 0;

  function automatic int popVec();
    int v = 0;
    int prev = 0;
    for (int r = 0; r < 8; r++) begin
      if (mBound[r] != prev) v |= (1 << r);
      prev = mBound[r];
    end
    return v;
  endfunction

  task automatic predict(input int page);
    int sh = 13 + ((mMode >> 18) & 1);
    int dual = (mMode >> 22) & 1;
    int eccOn = ((mMode >> 20) & 3) != 0;
    int pv = popVec();
    int prevC = 0;
    eMiss = 1; eRow = 0; eFirst = 0; eLast = 0; eChan = 0; eX4 = 0; eEcc = 0;
    for (int r = 0; r < 8; r++) begin
      int c = mBound[r] << sh;
      if (eMiss == 1 && ((pv >> r) & 1) == 1 && page < c) begin
        int sz = (c - prevC) & MASK;
        eMiss  = 0;
        eRow   = r;
        eFirst = prevC;
        eLast  = (c - 1) & MASK;
        eChan  = dual ? (sz >> 1) : sz;
        eX4    = (mAttr >> (4 * r + 3)) & 1;
        eEcc   = !eccOn ? 0 : ((dual && eX4) ? 2 : 1);
      end
      prevC = c;
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < 8; r++) mBound[r] = 0;
      mAttr = 0; mMode = 0; eValid = 0;
      eMiss = 0; eRow = 0; eFirst = 0; eLast = 0; eChan = 0; eX4 = 0; eEcc = 0;
    end else begin
      eValid = lkValid;
      predict(int'(lkPage));
      if (cfgWrEn) begin
        if (cfgAddr < 8) mBound[cfgAddr] = int'(cfgWrData[7:0]);
        else if (cfgAddr == 8) mAttr = int'(cfgWrData);
        else if (cfgAddr == 9) mMode = int'(cfgWrData);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (rstN) begin
      chk(rsValid == eValid[0], "R3 rsValid", rsValid, eValid);
      chk(rowPop == popVec(), "R5 rowPop", rowPop, popVec());
      if (eValid != 0) begin
        chk(rsMiss == eMiss[0], "R7 rsMiss", rsMiss, eMiss);
        chk(rsRow == eRow, "R6 rsRow", rsRow, eRow);
        chk(rsFirst == eFirst, "R4 rsFirst", rsFirst, eFirst);
        chk(rsLast == eLast, "R4 rsLast", rsLast, eLast);
        chk(rsX4 == eX4[0], "R8 rsX4", rsX4, eX4);
        chk(rsEcc == eEcc, "R9 rsEcc", rsEcc, eEcc);
        chk(rsChanPages == eChan, "R10 rsChanPages", rsChanPages, eChan);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'(a); cfgWrData = 32'(d);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Result of the lookup is read at the falling edge one cycle later.
  task automatic lk(input int page);
    @(negedge clk);
    lkValid = 1'b1; lkPage = 22'(page);
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(rsValid == 1'b0, "R2 rsValid in reset", rsValid, 0);
    chk(rowPop == 8'h00, "R2 rowPop in reset", rowPop, 0);
    rstN = 1'b1;
    lk(100);
    chk(rsMiss == 1'b1, "R2 miss after reset", rsMiss, 1);

    // Dual channel, ECC on, 32 MiB units; rows 1,3,4,7 empty; rows 0 and 5 x4.
    wr(9, (1 << 22) | (1 << 20));
    wr(8, (1 << 3) | (1 << 23));
    wr(0, 2); wr(1, 2); wr(2, 5); wr(3, 5);
    wr(4, 5); wr(5, 9); wr(6, 12); wr(7, 12);
    wr(12, 32'hFF); // R1: unmapped address ignored
    chk(rowPop == 8'b0110_0101, "R5 population map", rowPop, 8'h65);

    lk(0);
    chk(rsRow == 0 && !rsMiss, "R1 write visible", rsRow, 0);
    chk(rsEcc == 2, "R9 x4 dual gives symbol ECC", rsEcc, 2);
    chk(rsChanPages == 22'd8192, "R10 dual split", rsChanPages, 8192);
    lk(2 * 8192 - 1);
    chk(rsRow == 0 && rsLast == 22'(2 * 8192 - 1), "R4 last page of row", rsLast, 2 * 8192 - 1);
    lk(2 * 8192);
    chk(rsRow == 2, "R6 empty row skipped", rsRow, 2);
    chk(rsEcc == 1, "R9 x8 row SECDED", rsEcc, 1);
    lk(12 * 8192 - 1);
    chk(rsRow == 6, "R6 final populated row", rsRow, 6);
    lk(12 * 8192);
    chk(rsMiss == 1'b1 && rsRow == 0, "R7 beyond end misses", rsMiss, 1);

    // Same-cycle write and lookup: lookup uses old boundary.
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'd0; cfgWrData = 32'd0;
    lkValid = 1'b1; lkPage = 22'd0;
    @(negedge clk);
    cfgWrEn = 1'b0; lkValid = 1'b0;
    chk(rsRow == 0 && !rsMiss, "R1 same-cycle write unseen", rsRow, 0);
    lk(0);
    chk(rsRow == 1, "R1 write seen next cycle", rsRow, 1);

    // Single channel, 64 MiB units, bit 19 also set (no effect).
    wr(9, (1 << 18) | (1 << 19) | (1 << 21));
    lk(2 * 16384);
    chk(rsRow == 2 && rsFirst == 22'(2 * 16384), "R4 granularity 64 MiB", rsFirst, 2 * 16384);
    chk(rsChanPages == 22'(3 * 16384), "R10 single channel full size", rsChanPages, 3 * 16384);
    lk(5 * 16384);
    chk(rsEcc == 1 && rsX4 == 1'b1, "R9 x4 single SECDED", rsEcc, 1);

    // ECC disabled.
    wr(9, 0);
    lk(5 * 8192);
    chk(rsEcc == 0, "R9 ECC off", rsEcc, 0);

    // Random monotonic configurations and random lookups.
    for (int t = 0; t < 40; t++) begin
      int acc = 0;
      for (int r = 0; r < 8; r++) begin
        acc += $urandom_range(0, 3) * $urandom_range(0, 1);
        if (acc > 255) acc = 255;
        wr(r, acc);
      end
      wr(8, int'($urandom));
      wr(9, int'($urandom));
      for (int k = 0; k < 30; k++) lk(int'($urandom_range(0, 30 * 16384)));
    end

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule